// File: doc/BRIEF.md
# DSP Banked Flash Select Decoder

This block sits between a 24-bit DSP with a 16-bit address bus and an external flash part that is larger than one address space can reach. The DSP splits its accesses into a program space and two data spaces (X and Y), each 64K words. A program strobe, a data strobe and an X/Y select pick the space, and separate active-low read and write strobes qualify the cycle. The block decodes the upper part of the address map into an active-low flash select. It also supplies the flash address bits that the DSP bus cannot supply itself.

A small bank register, loaded over a one-cycle register port, pages a 16KB window of flash into the decoded region. Its three bits drive flash address bits 16 to 14. The DSP address passes straight through for bits 13 to 0. Flash bit 17 follows the program strobe level. Program fetches therefore land in the lower 128KB of flash, and X data reads land in the upper 128KB. Only reads from program space or X data space can select the flash.

Top module: `dsp_rom_decode`

## Requirements
- R1: After reset the bank register holds 0, so `flash_hi[2:0]` reads 0 and `rom_sel_n` is high while no access is presented.
- R2: When `cfg_we` is high at a rising clock edge, the bank register loads `cfg_bank`. The new value appears on `flash_hi[2:0]` after that edge and not before. Without `cfg_we` the value is held.
- R3: The address window is hit only when address bit 15 is 1 and at least one of bits 14 and 13 is 1, which covers $A000 to $FFFF. Outside the window `rom_sel_n` stays high.
- R4: A program-space read selects the flash (`rom_sel_n` = 0) inside the window. A program-space read has `prog_n`=0, `data_n`=1, `rd_n`=0 and `wr_n`=1.
- R5: An X data read also selects the flash inside the window. An X data read has `data_n`=0, `prog_n`=1, `x_sel`=1, `rd_n`=0 and `wr_n`=1. A Y data read (`x_sel`=0) never selects it.
- R6: The select stays high in all of these cases: `wr_n` is 0, `rd_n` is 1, both space strobes are low, or neither space strobe is low.
- R7: `flash_hi` carries flash address bits 17..14. Bits [2:0] equal the bank register and bit [3] equals the level of `prog_n`, so it is 0 for program space and 1 for X data space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsp_addr | input | 16 | DSP address bus |
| prog_n | input | 1 | Program space strobe, active low |
| data_n | input | 1 | Data space strobe, active low |
| x_sel | input | 1 | 1 selects X data, 0 selects Y data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cfg_we | input | 1 | Bank register write enable |
| cfg_bank | input | 3 | Bank value to load |
| rom_sel_n | output | 1 | Flash select, active low |
| flash_hi | output | 4 | Flash address bits 17..14 |

## Verification
The bench builds the block with its default 16-bit address and 3-bit bank field, so all eight banks and both 128KB halves can be reached in a short run. Directed reads at each bank in program and X data space check every combination of flash bits 17..14. Edge addresses $9FFF, $A000, $BFFF, $C000 and $FFFF test both boundaries of the window. Random strobe and address mixes check the write, Y-space and double-strobe exclusions against a bench model.

// File: rtl/dsp_rom_pkg.sv
package dsp_rom_pkg;

  // Memory space seen on the DSP bus for the current cycle.
  typedef enum logic [1:0] {
    SPC_IDLE  = 2'd0,
    SPC_PROG  = 2'd1,
    SPC_XDATA = 2'd2,
    SPC_YDATA = 2'd3
  } dsp_space_e;

  // Width of the flash page field above the pass-through bits.
  function automatic int page_bits(input int bank_w);
    return bank_w + 1;
  endfunction

endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dsp_space_decode.sv
module dsp_space_decode
  import dsp_rom_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              prog_n,
  input  logic              data_n,
  input  logic              x_sel,
  input  logic              rd_n,
  input  logic              wr_n,
  output dsp_space_e        space,
  output logic              win_hit,
  output logic              rd_cycle
);

  localparam int TOP = ADDR_W - 1;

  // Space from the strobe pair; both or neither low is idle.
  always_comb begin
    unique case ({prog_n, data_n})
      2'b01:   space = SPC_PROG;
      2'b10:   space = x_sel ? SPC_XDATA : SPC_YDATA;
      default: space = SPC_IDLE;
    endcase
  end

  // Upper window: top bit set and either of the next two set.
  always_comb begin
    win_hit = addr[TOP] & (addr[TOP-1] | addr[TOP-2]);
  end

  always_comb begin
    rd_cycle = ~rd_n & wr_n;
  end

endmodule

// File: rtl/dsp_bank_reg.sv
module dsp_bank_reg #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank_q
);

  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (load_en) begin
      bank_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else begin
      bank_q <= bank_d;
    end
  end

endmodule

// File: rtl/dsp_rom_decode.sv
module dsp_rom_decode
  import dsp_rom_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dsp_addr,
  input  logic              prog_n,
  input  logic              data_n,
  input  logic              x_sel,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cfg_we,
  input  logic [BANK_W-1:0] cfg_bank,
  output logic              rom_sel_n,
  output logic [BANK_W:0]   flash_hi
);

  localparam int HI_W = page_bits(BANK_W);

  logic              rst_core_n;
  dsp_space_e        space;
  logic              win_hit;
  logic              rd_cycle;
  logic [BANK_W-1:0] bank_q;
  logic              space_ok;
  logic [HI_W-1:0]   hi_bits;

  dsp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  dsp_space_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (dsp_addr),
    .prog_n   (prog_n),
    .data_n   (data_n),
    .x_sel    (x_sel),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .space    (space),
    .win_hit  (win_hit),
    .rd_cycle (rd_cycle)
  );

  dsp_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (cfg_we),
    .load_val (cfg_bank),
    .bank_q   (bank_q)
  );

  always_comb begin
    space_ok = (space == SPC_PROG) || (space == SPC_XDATA);
  end

  always_comb begin
    rom_sel_n = ~(space_ok & win_hit & rd_cycle);
  end

  // Top page bit follows the program strobe level; the bank field sits below it.
  always_comb begin
    hi_bits = {prog_n, bank_q};
  end

  assign flash_hi = hi_bits;

endmodule

// File: rtl/dsp_rom_decode_chk.sv
module dsp_rom_decode_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] dsp_addr,
  input logic              prog_n,
  input logic              data_n,
  input logic              x_sel,
  input logic              rd_n,
  input logic              wr_n,
  input logic              cfg_we,
  input logic [BANK_W-1:0] cfg_bank,
  input logic              rom_sel_n,
  input logic [BANK_W:0]   flash_hi
);

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= 2'd0;
    end else if (up_cnt != 2'd3) begin
      up_cnt <= up_cnt + 2'd1;
    end
  end

  // R3
  outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dsp_addr[ADDR_W-1] && (dsp_addr[ADDR_W-2] || dsp_addr[ADDR_W-3])) |-> rom_sel_n);

  // R5
  ydata_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_n && prog_n && !x_sel) |-> rom_sel_n);

  // R6
  write_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || rd_n || (prog_n == data_n)) |-> rom_sel_n);

  // R7
  prog_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_sel_n && !prog_n) |-> !flash_hi[BANK_W]);

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && up_cnt >= 2'd2) |=> (flash_hi[BANK_W-1:0] == $past(cfg_bank)));

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && up_cnt >= 2'd2) |=> $stable(flash_hi[BANK_W-1:0]));

endmodule

bind dsp_rom_decode dsp_rom_decode_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dsp_addr  (dsp_addr),
  .prog_n    (prog_n),
  .data_n    (data_n),
  .x_sel     (x_sel),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .cfg_we    (cfg_we),
  .cfg_bank  (cfg_bank),
  .rom_sel_n (rom_sel_n),
  .flash_hi  (flash_hi)
);

// File: tb/sim_dsp_rom_decode.sv
module sim_dsp_rom_decode;

  logic        clk;
  logic        rst_n;
  logic [15:0] dsp_addr;
  logic        prog_n, data_n, x_sel, rd_n, wr_n;
  logic        cfg_we;
  logic [2:0]  cfg_bank;
  logic        rom_sel_n;
  logic [3:0]  flash_hi;

  int n_cmp;
  int n_bad;
  logic [2:0] mdl_bank;

  dsp_rom_decode u0 (
    .clk(clk), .rst_n(rst_n), .dsp_addr(dsp_addr), .prog_n(prog_n),
    .data_n(data_n), .x_sel(x_sel), .rd_n(rd_n), .wr_n(wr_n),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .rom_sel_n(rom_sel_n),
    .flash_hi(flash_hi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic exp_sel(input logic [15:0] a, input logic p,
                                   input logic d, input logic x,
                                   input logic r, input logic w);
    logic hit, ok;
    hit = a[15] & (a[14] | a[13]);
    ok  = (!p && d) || (p && !d && x);
    return !(hit && ok && !r && w);
  endfunction

  function automatic logic [3:0] exp_hi(input logic p, input logic [2:0] b);
    return {p, b};
  endfunction

  task automatic cmp(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [15:0] a, input logic p,
                        input logic d, input logic x, input logic r, input logic w);
    @(negedge clk);
    dsp_addr = a; prog_n = p; data_n = d; x_sel = x; rd_n = r; wr_n = w;
    #1;
    cmp({req, " sel"}, {3'b0, rom_sel_n}, {3'b0, exp_sel(a, p, d, x, r, w)});
    cmp({req, " hi"}, flash_hi, exp_hi(p, mdl_bank));
  endtask

  task automatic bank_write(input logic [2:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = v;
    #1;
    // R2: old bank still visible before the edge
    cmp("R2 pre-edge", {1'b0, flash_hi[2:0]}, {1'b0, mdl_bank});
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    mdl_bank = v;
    cmp("R2 post-edge", {1'b0, flash_hi[2:0]}, {1'b0, mdl_bank});
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] v;
    n_cmp = 0; n_bad = 0; mdl_bank = 3'd0;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_bank = 3'd0;
    dsp_addr = 16'h0000; prog_n = 1'b1; data_n = 1'b1; x_sel = 1'b0;
    rd_n = 1'b1; wr_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1
    cmp("R1 reset bank", flash_hi, 4'b1000);
    cmp("R1 reset sel", {3'b0, rom_sel_n}, 4'b0001);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    access("R1 idle", 16'hC000, 1, 1, 1, 0, 1);

    // R3 window edges, program read, bank 0
    access("R3 9FFF", 16'h9FFF, 0, 1, 0, 0, 1);
    access("R3 A000", 16'hA000, 0, 1, 0, 0, 1);
    access("R3 BFFF", 16'hBFFF, 0, 1, 0, 0, 1);
    access("R3 C000", 16'hC000, 0, 1, 0, 0, 1);
    access("R3 FFFF", 16'hFFFF, 0, 1, 0, 0, 1);
    access("R3 7FFF", 16'h7FFF, 0, 1, 0, 0, 1);

    // R4 R5 R7 every bank in both spaces
    for (int b = 0; b < 8; b++) begin
      bank_write(3'(b));
      access("R4 R7 prog", 16'hE123, 0, 1, 0, 0, 1);
      access("R5 R7 xdata", 16'hB456, 1, 0, 1, 0, 1);
      access("R5 ydata", 16'hB456, 1, 0, 0, 0, 1);
    end

    // R6 exclusions
    access("R6 write", 16'hD000, 0, 1, 0, 1, 0);
    access("R6 no read", 16'hD000, 0, 1, 0, 1, 1);
    access("R6 both strobes", 16'hD000, 0, 0, 1, 0, 1);
    access("R6 no strobe", 16'hD000, 1, 1, 1, 0, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 8) == 0) begin
        v = 3'($urandom);
        bank_write(v);
      end
      access("R3 R4 R5 R6 R7 rand", 16'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 != 0));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule